// File: doc/BRIEF.md
# Serial Signature Analyzer

This block compacts a serial stream of test responses into a short signature and judges it against a known-good value. Each bit presented while the valid strobe is high is folded into a 5-stage divider register. The stream is read as a polynomial whose first bit carries the highest power. After the last bit the register holds that polynomial's remainder modulo x^5 + x^4 + x^2 + 1.

A test run starts with a synchronous clear, streams its response bits, and then raises `done` once. One cycle later the `pass` flag shows whether the signature matched the expected value presented on `exp_sig` alongside `done`. The flag then holds until the next clear.

Two different responses can leave the same remainder. Such a faulty stream is judged good, and the block raises nothing to mark it.

Top module: `sig_analyzer`

## Requirements
- R1: After `rst`, or after a cycle with `clr` high, `sig` is 0 and `pass` is 0.
- R2: On each cycle with `vld` high and `clr` low, the register becomes (x·S(x) + din) mod (x^5+x^4+x^2+1), where `sig[k]` is the coefficient of x^k. Over a whole run, `sig` therefore equals the stream polynomial modulo that divisor, with the first bit as the highest power.
- R3: Starting from a cleared register, the stream 1,1,1,1,0,1,0,1 leaves `sig` = 5'b10100, which is x^4 + x^2.
- R4: With `vld` low and `clr` low, `sig` keeps its value whatever `din` does.
- R5: The first `done` after a clear sets `pass` in the next cycle to 1 if `sig` equals `exp_sig`, and to 0 otherwise.
- R6: Once a judgement is made, `pass` does not change until the next clear or reset, even if further `done` pulses arrive with other `exp_sig` values.
- R7: `clr` takes priority over `vld` and `done` in the same cycle.
- R8: When `done` and `vld` are high in the same cycle, the comparison uses `sig` as it stood before that cycle's bit, and the bit is still shifted in.
- R9: A stream that differs from the good one by a multiple of the divisor gets the same signature and is judged as passing. For example, 1,1,0,0,0,0,0,0 gives 5'b10100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear at the start of a run |
| vld | input | 1 | Qualifies `din` for this cycle |
| din | input | 1 | Serial response bit |
| done | input | 1 | Requests the judgement of the current signature |
| exp_sig | input | 5 | Known-good signature, sampled with `done` |
| sig | output | 5 | Current remainder; bit k is the x^k coefficient |
| pass | output | 1 | Registered match result, held until clear |

## Verification
The bench builds the block with its default width of 5 and tap mask 5'b10101, which are the low-order terms of the divisor. With these values the worked eight-bit example and the aliasing stream give fixed signatures that can be checked by hand. A long pseudo-random stream, interleaved with idle cycles, is compared each clock with a remainder computed by ordinary long division. This exercises every feedback path and every hold condition. Collisions among `clr`, `vld` and `done` in the same cycle are driven deliberately, so the priority and ordering rules are checked as well.

// File: rtl/sig_pkg.sv
package sig_pkg;
    localparam int unsigned DEF_W = 5;
    // low-order divisor terms: x^0, x^2, x^4 (x^5 implied by the width)
    localparam logic [DEF_W-1:0] DEF_TAPS = 5'b10101;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    typedef struct packed {
        logic clr;
        logic vld;
        logic din;
        logic done;
    } ctrl_t;

    function automatic op_e decode_op(input ctrl_t c);
        if (c.clr)      return OP_CLEAR;
        else if (c.vld) return OP_SHIFT;
        else            return OP_IDLE;
    endfunction
endpackage

// File: rtl/sig_div.sv
module sig_div
    import sig_pkg::*;
#(
    parameter int unsigned     W    = DEF_W,
    parameter logic [W-1:0]    TAPS = DEF_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctl,
    output logic [W-1:0] rem_q
);
    logic [W-1:0] rem_nxt;
    logic         fb;
    op_e          op;

    assign fb = rem_q[W-1];
    assign op = decode_op(ctl);

    for (genvar i = 0; i < int'(W); i++) begin : g_stage
        if (i == 0) begin : g_in
            assign rem_nxt[i] = ctl.din ^ (TAPS[i] & fb);
        end else begin : g_mid
            assign rem_nxt[i] = rem_q[i-1] ^ (TAPS[i] & fb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: rem_q <= '0;
                OP_SHIFT: rem_q <= rem_nxt;
                default:  rem_q <= rem_q;
            endcase
        end
    end

    // R1 / R7: clear wins and empties the register
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (rem_q == '0));
    // R4: idle cycles hold
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.vld) |=> $stable(rem_q));
    // R2: zero remainder stays zero under zero input
    p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.vld && !ctl.din && rem_q == '0) |=> (rem_q == '0));
endmodule

// File: rtl/sig_judge.sv
module sig_judge
    import sig_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctl,
    input  logic [W-1:0] cur_sig,
    input  logic [W-1:0] ref_sig,
    output logic         pass_q
);
    logic judged_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            pass_q   <= 1'b0;
            judged_q <= 1'b0;
        end else if (ctl.done && !judged_q) begin
            pass_q   <= (cur_sig == ref_sig);
            judged_q <= 1'b1;
        end
    end

    // R5 / R8: verdict reflects the pre-shift signature of the done cycle
    p_verdict_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.done && !judged_q && !ctl.clr) |=> (pass_q == ($past(cur_sig) == $past(ref_sig))));
    // R6: verdict frozen until clear
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (judged_q && !ctl.clr) |=> $stable(pass_q));
    // R1: clear drops the verdict
    p_clear_pass_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> !pass_q);
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
    import sig_pkg::*;
#(
    parameter int unsigned  SIG_W = DEF_W,
    parameter logic [SIG_W-1:0] TAPS = DEF_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             vld,
    input  logic             din,
    input  logic             done,
    input  logic [SIG_W-1:0] exp_sig,
    output logic [SIG_W-1:0] sig,
    output logic             pass
);
    ctrl_t ctl;

    assign ctl = '{clr: clr, vld: vld, din: din, done: done};

    sig_div #(.W(SIG_W), .TAPS(TAPS)) u_div (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rem_q (sig)
    );

    sig_judge #(.W(SIG_W)) u_judge (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .cur_sig (sig),
        .ref_sig (exp_sig),
        .pass_q  (pass)
    );

    // R1: reset leaves a clean state
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sig == '0 && !pass));
endmodule

// File: tb/sim_sig_analyzer.sv
module sim_sig_analyzer;
    localparam int CLK_P = 10;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         vld = 1'b0;
    logic         din = 1'b0;
    logic         done = 1'b0;
    logic [W-1:0] exp_sig = '0;
    logic [W-1:0] sig;
    logic         pass;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_rem    = 0;
    bit m_pass   = 0;
    bit m_judged = 0;

    always #(CLK_P/2) clk = ~clk;

    sig_analyzer u0 (
        .clk(clk), .rst(rst), .clr(clr), .vld(vld), .din(din),
        .done(done), .exp_sig(exp_sig), .sig(sig), .pass(pass)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input bit c, input bit v, input bit d,
                        input bit dn, input int e);
        @(negedge clk);
        clr = c; vld = v; din = d; done = dn; exp_sig = e[W-1:0];
        @(posedge clk);
        #1;
        if (rst || c) begin
            m_rem = 0; m_pass = 0; m_judged = 0;
        end else begin
            if (dn && !m_judged) begin
                m_pass = (m_rem == e);
                m_judged = 1;
            end
            if (v) begin
                m_rem = (m_rem << 1) | int'(d);
                if (m_rem & 32) m_rem = m_rem ^ 'b110101; // x^5+x^4+x^2+1
            end
        end
        check({req, " sig"}, int'(sig), m_rem);
        check({req, " pass"}, int'(pass), int'(m_pass));
    endtask

    task automatic feed(input string req, input bit [7:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) step(req, 0, 1, bits[i], 0, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lcg;
        // R1: reset
        step("R1", 0, 1, 1, 1, 0);
        step("R1", 0, 0, 0, 0, 0);
        rst = 1'b0;
        step("R1", 0, 0, 0, 0, 0);
        check("R1 reset sig", int'(sig), 0);

        // R3: worked example, then R5 verdict
        step("R1", 1, 0, 0, 0, 0);
        feed("R3", 8'b11110101, 8);
        check("R3 example", int'(sig), 'b10100);
        step("R5", 0, 0, 0, 1, 'b10100);
        check("R5 match", int'(pass), 1);
        // R6: later done with wrong value ignored
        step("R6", 0, 0, 0, 1, 'b00001);
        step("R6", 0, 0, 0, 1, 'b00000);
        check("R6 frozen", int'(pass), 1);

        // R4: idle cycles with toggling din
        step("R1", 1, 0, 0, 0, 0);
        feed("R2", 8'b10110111, 8);
        for (int i = 0; i < 6; i++) step("R4", 0, 0, i[0], 0, 0);
        feed("R2", 8'b01100011, 8);
        step("R5", 0, 0, 0, 1, 'b11111);
        check("R5 mismatch", int'(pass), int'(m_pass));

        // R9: aliasing stream passes
        step("R1", 1, 0, 0, 0, 0);
        feed("R9", 8'b11000000, 8);
        check("R9 alias sig", int'(sig), 'b10100);
        step("R9", 0, 0, 0, 1, 'b10100);
        check("R9 alias pass", int'(pass), 1);

        // R7: clear together with vld and done
        step("R7", 1, 1, 1, 1, 0);
        check("R7 clear wins", int'(sig), 0);
        check("R7 no verdict", int'(pass), 0);

        // R8: done and vld in the same cycle
        feed("R8", 8'b11110101, 8);
        step("R8", 0, 1, 1, 1, 'b10100);
        check("R8 pre-shift compare", int'(pass), 1);
        check("R8 bit still shifted", int'(sig), m_rem);

        // R2: long pseudo-random stream with gaps
        step("R1", 1, 0, 0, 0, 0);
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            step("R2", 0, lcg[20] | lcg[21], lcg[16], 0, 0);
        end
        step("R5", 0, 0, 0, 1, m_rem);
        check("R5 random match", int'(pass), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule